// File: doc/BRIEF.md
# Wide-Word Load Realigner

The realigner turns a stream of 64-byte memory fetches into a stream of 72-byte register words. Since a 72-byte word never lines up with the 64-byte fetch width, the block keeps a holding file of leftover bytes. It also keeps an issue-side offset, which counts the bytes buffered or still in flight. A prime command preloads one fetch. Each take command then produces exactly one 72-byte word and advances the stream pointer by 72.

A take fetches the next 64 bytes at pointer plus offset. It glues the buffered bytes in front of them and returns the first 72. When 72 or more bytes are already held, it is served from the holding file alone and no fetch is made. The memory port has a fixed read latency. Commands are fully pipelined, so back-to-back takes return one word per cycle, each exactly 8 cycles after issue.

A misuse of the protocol is flagged by a one-cycle error pulse, and the offending command is ignored. There are three such misuses:
- a take with too few bytes available;
- a prime that would overflow the holding file;
- a plain load placed right after a take.

Top module: `realign_top`

## Requirements
- R1: After reset `out_valid`, `err` and `mem_req` are 0. The pointer and offset are 0, so a first prime fetches at address 0.
- R2: Command code 0 (set pointer) loads `cmd_addr` into the pointer, clears the offset to 0 and discards every held byte. It makes no fetch and raises no error.
- R3: Command code 1 (prime) fetches 64 bytes at pointer+offset and raises the offset by 64. If the offset exceeds 64 before the prime, the prime is refused: `err` pulses one cycle later, there is no fetch and the state does not change.
- R4: Command code 2 (take) with an offset from 8 to 71 fetches at pointer+offset. It then advances the pointer by 72 and lowers the offset by 8.
- R5: A take with an offset of 72 or more makes no fetch and is served from held bytes only. It advances the pointer by 72 and lowers the offset by 72.
- R6: Byte i of the result, `out_word[8i+7:8i]`, is the memory byte at (pointer when the take was issued) + i. Memory byte j of a fetch arrives on `mem_rdata[8j+7:8j]`.
- R7: `out_valid` is high for one cycle, exactly 8 clock edges after the edge that accepted a take. It is high at no other time, and takes on consecutive cycles give words on consecutive cycles.
- R8: A take with an offset below 8 is refused: `err` pulses on the next cycle, there is no fetch, no word is produced and the pointer and offset are unchanged.
- R9: Command code 3 (plain load) pulses `err` on the next cycle if a take was accepted on the cycle just before it. Otherwise it has no effect at all.
- R10: Two fetches on consecutive cycles have addresses 64 bytes apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 set pointer, 1 prime, 2 take, 3 plain load |
| cmd_addr | input | ADDR_W | New pointer for a set-pointer command |
| mem_req | output | 1 | Fetch request, same cycle as its command |
| mem_addr | output | ADDR_W | Byte address of the fetch |
| mem_rdata | input | 512 | Fetch data, RD_LAT cycles after the request |
| out_valid | output | 1 | Realigned word valid |
| out_word | output | 576 | Realigned 72-byte word, byte 0 in the low bits |
| err | output | 1 | Protocol error pulse |

## Verification
The assertions assume two things about the inputs. First, the memory answers every request after exactly RD_LAT cycles. Second, no command is driven while reset is high, so the fetch-address and plain-after-take properties never see a fetch that reset dropped. The bench memory is a pure shift of addresses into a byte function, so its latency is fixed by construction. The bench drives commands only after reset has been released. Its stream tests use pointers that are not aligned to 64 bytes, and they run to the edge of the holding file, so that every stitch position of the offset counter is reached.

// File: rtl/realign_pkg.sv
package realign_pkg;

    localparam int FETCH_BYTES_D = 64;
    localparam int WORD_BYTES_D  = 72;
    localparam int HOLD_BYTES_D  = 128;

    typedef enum logic [1:0] {
        CMD_SETPTR = 2'd0,
        CMD_PRIME  = 2'd1,
        CMD_TAKE   = 2'd2,
        CMD_PLAIN  = 2'd3
    } cmd_op_e;

    typedef enum logic [2:0] {
        STEP_NONE,
        STEP_CLEAR,
        STEP_PRIME,
        STEP_TAKE_FETCH,
        STEP_TAKE_BUF
    } step_e;

    function automatic logic step_is_take(input step_e s);
        return (s == STEP_TAKE_FETCH) || (s == STEP_TAKE_BUF);
    endfunction

    function automatic logic step_appends(input step_e s);
        return (s == STEP_PRIME) || (s == STEP_TAKE_FETCH);
    endfunction

endpackage

// File: rtl/realign_issue.sv
module realign_issue
    import realign_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int FETCH_BYTES = FETCH_BYTES_D,
    parameter int WORD_BYTES  = WORD_BYTES_D,
    parameter int HOLD_BYTES  = HOLD_BYTES_D,
    parameter int OFF_W       = $clog2(HOLD_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output step_e             step,
    output logic [OFF_W-1:0]  offset,
    output logic              err
);
    localparam logic [OFF_W-1:0] PRIME_LIMIT = OFF_W'(HOLD_BYTES - FETCH_BYTES);
    localparam logic [OFF_W-1:0] TAKE_MIN    = OFF_W'(WORD_BYTES - FETCH_BYTES);
    localparam logic [OFF_W-1:0] BUF_MIN     = OFF_W'(WORD_BYTES);

    logic [ADDR_W-1:0] ptr_q;
    logic [OFF_W-1:0]  off_q;
    logic              last_take_q;
    logic              bad;
    cmd_op_e           op;

    always_comb begin
        op   = cmd_op_e'(cmd_op);
        step = STEP_NONE;
        bad  = 1'b0;
        if (cmd_valid) begin
            unique case (op)
                CMD_SETPTR: step = STEP_CLEAR;
                CMD_PRIME:  if (off_q <= PRIME_LIMIT) step = STEP_PRIME;
                            else bad = 1'b1;
                CMD_TAKE:   if (off_q >= BUF_MIN) step = STEP_TAKE_BUF;
                            else if (off_q >= TAKE_MIN) step = STEP_TAKE_FETCH;
                            else bad = 1'b1;
                CMD_PLAIN:  bad = last_take_q;
                default:    bad = 1'b0;
            endcase
        end
    end

    assign mem_req  = step_appends(step);
    assign mem_addr = ptr_q + ADDR_W'(off_q);
    assign offset   = off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q       <= '0;
            off_q       <= '0;
            last_take_q <= 1'b0;
            err         <= 1'b0;
        end else begin
            err         <= bad;
            last_take_q <= step_is_take(step);
            unique case (step)
                STEP_CLEAR: begin
                    ptr_q <= cmd_addr;
                    off_q <= '0;
                end
                STEP_PRIME: off_q <= off_q + OFF_W'(FETCH_BYTES);
                STEP_TAKE_FETCH: begin
                    ptr_q <= ptr_q + ADDR_W'(WORD_BYTES);
                    off_q <= off_q - OFF_W'(WORD_BYTES - FETCH_BYTES);
                end
                STEP_TAKE_BUF: begin
                    ptr_q <= ptr_q + ADDR_W'(WORD_BYTES);
                    off_q <= off_q - OFF_W'(WORD_BYTES);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/realign_merge.sv
module realign_merge
    import realign_pkg::*;
#(
    parameter int FETCH_BYTES = FETCH_BYTES_D,
    parameter int WORD_BYTES  = WORD_BYTES_D,
    parameter int HOLD_BYTES  = HOLD_BYTES_D,
    parameter int OFF_W       = $clog2(HOLD_BYTES + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  step_e                     step,
    input  logic [FETCH_BYTES*8-1:0]  rdata,
    output logic                      word_valid,
    output logic [WORD_BYTES*8-1:0]   word,
    output logic [OFF_W-1:0]          hold_cnt
);
    localparam int MRG = HOLD_BYTES + WORD_BYTES;

    logic [7:0]              hold_q [HOLD_BYTES];
    logic [7:0]              hold_d [HOLD_BYTES];
    logic [7:0]              merged [MRG];
    logic [OFF_W-1:0]        cnt_q;
    logic [WORD_BYTES*8-1:0] word_d;
    logic                    append, remove;
    int                      cnt_next;

    assign append = step_appends(step);
    assign remove = step_is_take(step);

    always_comb begin
        for (int j = 0; j < MRG; j++) merged[j] = 8'h00;
        for (int j = 0; j < HOLD_BYTES; j++)
            if (j < int'(cnt_q)) merged[j] = hold_q[j];
        if (append)
            for (int k = 0; k < FETCH_BYTES; k++)
                merged[int'(cnt_q) + k] = rdata[8*k +: 8];
        for (int i = 0; i < WORD_BYTES; i++) word_d[8*i +: 8] = merged[i];
        for (int j = 0; j < HOLD_BYTES; j++)
            hold_d[j] = remove ? merged[j + WORD_BYTES] : merged[j];
        cnt_next = int'(cnt_q) + (append ? FETCH_BYTES : 0) - (remove ? WORD_BYTES : 0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            word_valid <= 1'b0;
            word       <= '0;
            for (int j = 0; j < HOLD_BYTES; j++) hold_q[j] <= 8'h00;
        end else begin
            word_valid <= remove;
            word       <= remove ? word_d : '0;
            if (step == STEP_CLEAR) begin
                cnt_q <= '0;
                for (int j = 0; j < HOLD_BYTES; j++) hold_q[j] <= 8'h00;
            end else if (step != STEP_NONE) begin
                cnt_q <= OFF_W'(cnt_next);
                for (int j = 0; j < HOLD_BYTES; j++) hold_q[j] <= hold_d[j];
            end
        end
    end

    assign hold_cnt = cnt_q;
endmodule

// File: rtl/realign_delay.sv
module realign_delay #(
    parameter int W      = 576,
    parameter int STAGES = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    generate
        if (STAGES == 0) begin : g_pass
            assign out_valid = in_valid;
            assign out_data  = in_data;
        end else begin : g_chain
            logic [W-1:0] d_q [STAGES];
            logic [STAGES-1:0] v_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    v_q <= '0;
                    for (int i = 0; i < STAGES; i++) d_q[i] <= '0;
                end else begin
                    v_q[0] <= in_valid;
                    d_q[0] <= in_data;
                    for (int i = 1; i < STAGES; i++) begin
                        v_q[i] <= v_q[i-1];
                        d_q[i] <= d_q[i-1];
                    end
                end
            end
            assign out_valid = v_q[STAGES-1];
            assign out_data  = d_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/realign_top.sv
module realign_top
    import realign_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int FETCH_BYTES = FETCH_BYTES_D,
    parameter int WORD_BYTES  = WORD_BYTES_D,
    parameter int HOLD_BYTES  = HOLD_BYTES_D,
    parameter int RD_LAT      = 3,
    parameter int POP_LAT     = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cmd_valid,
    input  logic [1:0]               cmd_op,
    input  logic [ADDR_W-1:0]        cmd_addr,
    output logic                     mem_req,
    output logic [ADDR_W-1:0]        mem_addr,
    input  logic [FETCH_BYTES*8-1:0] mem_rdata,
    output logic                     out_valid,
    output logic [WORD_BYTES*8-1:0]  out_word,
    output logic                     err
);
    localparam int OFF_W  = $clog2(HOLD_BYTES + 1);
    localparam int EXTRA  = POP_LAT - RD_LAT;

    step_e             issue_step;
    logic [OFF_W-1:0]  issue_off;
    logic [OFF_W-1:0]  hold_cnt;
    step_e             step_pipe [RD_LAT];
    logic              mrg_valid;
    logic [WORD_BYTES*8-1:0] mrg_word;

    realign_issue #(
        .ADDR_W(ADDR_W), .FETCH_BYTES(FETCH_BYTES), .WORD_BYTES(WORD_BYTES),
        .HOLD_BYTES(HOLD_BYTES), .OFF_W(OFF_W)
    ) u_issue (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .mem_req(mem_req), .mem_addr(mem_addr),
        .step(issue_step), .offset(issue_off), .err(err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RD_LAT; i++) step_pipe[i] <= STEP_NONE;
        end else begin
            step_pipe[0] <= issue_step;
            for (int i = 1; i < RD_LAT; i++) step_pipe[i] <= step_pipe[i-1];
        end
    end

    realign_merge #(
        .FETCH_BYTES(FETCH_BYTES), .WORD_BYTES(WORD_BYTES),
        .HOLD_BYTES(HOLD_BYTES), .OFF_W(OFF_W)
    ) u_merge (
        .clk(clk), .rst(rst), .step(step_pipe[RD_LAT-1]), .rdata(mem_rdata),
        .word_valid(mrg_valid), .word(mrg_word), .hold_cnt(hold_cnt)
    );

    realign_delay #(.W(WORD_BYTES*8), .STAGES(EXTRA)) u_delay (
        .clk(clk), .rst(rst), .in_valid(mrg_valid), .in_data(mrg_word),
        .out_valid(out_valid), .out_data(out_word)
    );
endmodule

// File: rtl/realign_chk.sv
module realign_chk
    import realign_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int FETCH_BYTES = FETCH_BYTES_D,
    parameter int WORD_BYTES  = WORD_BYTES_D,
    parameter int HOLD_BYTES  = HOLD_BYTES_D,
    parameter int POP_LAT     = 8,
    parameter int OFF_W       = $clog2(HOLD_BYTES + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              out_valid,
    input logic              err,
    input step_e             issue_step,
    input logic [OFF_W-1:0]  issue_off,
    input logic [OFF_W-1:0]  hold_cnt
);
    logic [POP_LAT:0] take_hist;

    always_ff @(posedge clk) begin
        if (rst) take_hist <= '0;
        else     take_hist <= {take_hist[POP_LAT-1:0], step_is_take(issue_step)};
    end

    p_fetch_contiguous_r10: assert property (@(posedge clk) disable iff (rst)
        mem_req && $past(mem_req) |-> mem_addr == $past(mem_addr) + ADDR_W'(FETCH_BYTES));

    p_err_no_fetch_r8: assert property (@(posedge clk) disable iff (rst)
        err |-> !$past(mem_req));

    p_out_latency_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid == take_hist[POP_LAT]);

    p_offset_bounds_r3: assert property (@(posedge clk) disable iff (rst)
        issue_off <= OFF_W'(HOLD_BYTES) && issue_off[2:0] == 3'b000);

    p_hold_bounds_r5: assert property (@(posedge clk) disable iff (rst)
        hold_cnt <= OFF_W'(HOLD_BYTES));

    p_plain_after_take_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_op == 2'd3 && $past(step_is_take(issue_step)) |=> err);
endmodule

bind realign_top realign_chk #(
    .ADDR_W(ADDR_W), .FETCH_BYTES(FETCH_BYTES), .WORD_BYTES(WORD_BYTES),
    .HOLD_BYTES(HOLD_BYTES), .POP_LAT(POP_LAT)
) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .mem_req(mem_req), .mem_addr(mem_addr), .out_valid(out_valid), .err(err),
    .issue_step(issue_step), .issue_off(issue_off), .hold_cnt(hold_cnt)
);

// File: tb/realign_top_tb.sv
module realign_top_tb;
    localparam int RD_LAT = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cmd_valid = 1'b0;
    logic [1:0]   cmd_op = 2'd0;
    logic [31:0]  cmd_addr = '0;
    logic         mem_req;
    logic [31:0]  mem_addr;
    logic [511:0] mem_rdata;
    logic         out_valid;
    logic [575:0] out_word;
    logic         err;

    always #4 clk = ~clk;

    realign_top #(.RD_LAT(RD_LAT), .POP_LAT(8)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .out_valid(out_valid), .out_word(out_word), .err(err)
    );

    function automatic logic [7:0] mb(input logic [31:0] a);
        return (a[7:0] + {a[10:8], 5'b0}) ^ 8'hA5;
    endfunction

    function automatic logic [575:0] word_at(input logic [31:0] p);
        logic [575:0] w;
        for (int i = 0; i < 72; i++) w[8*i +: 8] = mb(p + 32'(i));
        return w;
    endfunction

    logic [31:0] mq [RD_LAT];
    always @(posedge clk) begin
        for (int i = RD_LAT - 1; i > 0; i--) mq[i] <= mq[i-1];
        mq[0] <= mem_addr;
    end
    always_comb
        for (int i = 0; i < 64; i++) mem_rdata[8*i +: 8] = mb(mq[RD_LAT-1] + 32'(i));

    int checks = 0, failures = 0, cyc = 0;
    bit done = 0;

    logic [31:0]  m_ptr = '0;
    int           m_off = 0;
    bit           m_lastpop = 0;
    bit           e_err = 0;
    string        e_tag = "R1";
    bit           e_ov [16];
    logic [575:0] e_w [16];
    bit           p_fetch = 0;
    logic [31:0]  p_addr = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [575:0] act, input logic [575:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit v, input logic [1:0] op, input logic [31:0] a);
        bit fetch, bad, pop;
        logic [31:0] faddr;
        string t;
        int slot;
        @(negedge clk);
        slot = cyc % 16;
        chk(err === e_err, e_tag, "err", 576'(err), 576'(e_err));
        chk(out_valid === e_ov[slot], "R7", "out_valid", 576'(out_valid), 576'(e_ov[slot]));
        if (e_ov[slot]) chk(out_word === e_w[slot], "R6", "out_word", out_word, e_w[slot]);
        e_ov[slot] = 0;
        cmd_valid = v; cmd_op = op; cmd_addr = a;
        #1;
        fetch = 0; bad = 0; pop = 0; t = "R1";
        if (v) begin
            case (op)
                2'd0: t = "R2";
                2'd1: begin t = "R3"; if (m_off + 64 <= 128) fetch = 1; else bad = 1; end
                2'd2: begin
                    if (m_off >= 72) begin t = "R5"; pop = 1; end
                    else if (m_off >= 8) begin t = "R4"; pop = 1; fetch = 1; end
                    else begin t = "R8"; bad = 1; end
                end
                default: begin t = "R9"; bad = m_lastpop; end
            endcase
        end
        faddr = m_ptr + 32'(m_off);
        chk(mem_req === fetch, t, "mem_req", 576'(mem_req), 576'(fetch));
        if (fetch) chk(mem_addr === faddr, t, "mem_addr", 576'(mem_addr), 576'(faddr));
        if (fetch && p_fetch)
            chk(mem_addr === p_addr + 32'd64, "R10", "fetch stride", 576'(mem_addr), 576'(p_addr + 32'd64));
        p_fetch = fetch;
        p_addr  = faddr;
        @(posedge clk);
        cyc++;
        if (v) begin
            case (op)
                2'd0: begin m_ptr = a; m_off = 0; end
                2'd1: if (fetch) m_off += 64;
                2'd2: if (pop) begin
                    e_ov[(cyc + 8) % 16] = 1;
                    e_w[(cyc + 8) % 16]  = word_at(m_ptr);
                    m_ptr += 32'd72;
                    m_off -= fetch ? 8 : 72;
                end
                default: ;
            endcase
        end
        m_lastpop = pop;
        e_err = bad;
        e_tag = t;
    endtask

    task automatic take_n(input int n);
        for (int i = 0; i < n; i++) begin
            if (m_off < 8) step(1, 2'd1, '0);
            step(1, 2'd2, '0);
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin e_ov[i] = 0; e_w[i] = '0; end
        for (int i = 0; i < 3; i++) step(0, 2'd0, '0);
        #1 rst = 1'b0;
        chk(mem_req === 1'b0 && out_valid === 1'b0 && err === 1'b0, "R1", "reset outputs",
            576'({mem_req, out_valid, err}), 576'(0));
        // R1: first prime without a set-pointer fetches at address 0
        step(1, 2'd1, '0);
        // R4 R7: long back-to-back take stream with primes as needed
        take_n(20);
        // R5 R3: fill to capacity, overflow prime, buffered take, unaligned base
        step(1, 2'd0, 32'h0000_2003);
        step(1, 2'd1, '0);
        step(1, 2'd1, '0);
        step(1, 2'd1, '0);
        step(1, 2'd2, '0);
        take_n(4);
        // R8 R9: underflow take, plain after take, plain after idle
        step(1, 2'd0, 32'h0000_3000);
        step(1, 2'd2, '0);
        step(1, 2'd1, '0);
        step(1, 2'd2, '0);
        step(1, 2'd3, '0);
        step(0, 2'd0, '0);
        step(1, 2'd3, '0);
        step(1, 2'd2, '0);
        // R2: set pointer mid-stream discards held bytes and clears the offset
        step(1, 2'd0, 32'h0000_4101);
        step(1, 2'd1, '0);
        step(1, 2'd2, '0);
        step(1, 2'd0, 32'h0000_5000);
        step(1, 2'd2, '0);
        step(1, 2'd1, '0);
        step(1, 2'd2, '0);
        take_n(10);
        for (int i = 0; i < 12; i++) step(0, 2'd0, '0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule